// File: doc/BRIEF.md
# Interrupt Acknowledge Priority Chain

This block collects interrupt requests from a row of source nodes and reports them to a processor on one shared request line. Each node keeps its own pending flag, set by a request pulse from its source, and a programmable identifier word written through a small configuration port. The request line is high whenever at least one node is pending.

When the processor answers with an acknowledge, the grant enters node 0 and ripples node by node within the same cycle. The first pending node it meets claims it, stops it from travelling further, and clears its own pending flag. On the next cycle its identifier word appears on the shared vector bus with a valid flag, so the processor can pick the matching handler. Position in the row is the only priority: a lower index always wins. If the grant passes every node unclaimed it leaves on a chain output, and the vector bus stays idle.

Top module: `irq_daisy_chain`

## Requirements
- R1: After reset, irq_out, vec_valid, vec_data and ack_out are all 0, no node is pending, and every identifier word is 0.
- R2: A 1 on req_set[i] at a clock edge marks node i pending; irq_out is the OR of all pending flags and rises on the cycle after the first request.
- R3: During a cycle with int_ack high, the pending node with the lowest index claims the grant; no node above it claims.
- R4: The claiming node's identifier word is driven on vec_data with vec_valid high on the cycle after the acknowledge cycle, for exactly one cycle.
- R5: Whenever vec_valid is 0, vec_data is all zeros; this includes an acknowledge that no pending node claims.
- R6: ack_out is high in the same cycle that int_ack is high and no node is pending.
- R7: The claiming node's pending flag is cleared at the end of the acknowledge cycle, other pending flags are kept, and a req_set to the claiming node in that same cycle leaves it pending.
- R8: With cfg_we high, cfg_vec is stored as the identifier word of node cfg_idx and held until rewritten; a write with cfg_idx of NODES or more changes no node.
- R9: A write to the claiming node in the acknowledge cycle does not change the word driven for that claim; the new word applies to later claims.
- R10: Pending nodes with int_ack low keep their flags and produce no vector output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_set | input | NODES | Per-node request pulses |
| cfg_we | input | 1 | Identifier word write enable |
| cfg_idx | input | IDX_W | Node selected for the write |
| cfg_vec | input | VEC_W | Identifier word to store |
| int_ack | input | 1 | Acknowledge from the processor, enters node 0 |
| irq_out | output | 1 | Shared request line, OR of all pending flags |
| ack_out | output | 1 | Grant leaving the last node unclaimed |
| vec_valid | output | 1 | Vector bus holds a claimed identifier |
| vec_data | output | VEC_W | Identifier of the claiming node, zero when idle |

## Verification
A pending flag that is wrong inside the block shows up in three places: irq_out one cycle later, ack_out in the very next acknowledge cycle, and the word on vec_data the cycle after that acknowledge. A stale or corrupted identifier register stays invisible until its node wins, so the bench reloads words often and drains the chain in order to make every node win repeatedly. A broken grant ripple shows as the wrong identifier or a second claimant in the cycle after an acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int DEF_NODES = 6;
  localparam int DEF_VEC_W = 8;

  // Width of a node index; at least one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/icn_node.sv
module icn_node #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             grant_in,
  output logic             grant_out,
  output logic             claim,
  output logic             pend,
  output logic [VEC_W-1:0] vec_claimed
);
  logic             pend_q, pend_d, pend_en;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    claim       = grant_in & pend_q;
    grant_out   = grant_in & ~pend_q;
    pend_en     = req_set | claim;
    pend_d      = req_set | (pend_q & ~claim);
    vec_claimed = claim ? vec_q : '0;
    pend        = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (wr_en) begin
      vec_q <= wr_vec;
    end
  end

  assert_win_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !req_set) |=> !pend_q);

  assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vec_q));

  assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !grant_in) |=> pend_q);
endmodule

// File: rtl/icn_vec_out.sv
module icn_vec_out #(
  parameter int NODES = 6,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NODES-1:0]       claim,
  input  logic [NODES*VEC_W-1:0] vec_flat,
  output logic                   vec_valid,
  output logic [VEC_W-1:0]       vec_data
);
  logic             valid_d;
  logic [VEC_W-1:0] data_d;

  always_comb begin
    valid_d = |claim;
    data_d  = '0;
    for (int i = 0; i < NODES; i++) begin
      data_d = data_d | vec_flat[i*VEC_W +: VEC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= valid_d;
      vec_data  <= data_d;
    end
  end

  assert_single_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_data == '0));
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int NODES = DEF_NODES,
  parameter int VEC_W = DEF_VEC_W,
  parameter int IDX_W = idx_width(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] req_set,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             int_ack,
  output logic             irq_out,
  output logic             ack_out,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data
);
  logic [1:0]             rst_sync_q;
  logic                   rst_n_s;
  logic [NODES:0]         grant;
  logic [NODES-1:0]       claim, pend, wr_sel;
  logic [NODES*VEC_W-1:0] vec_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign grant[0] = int_ack;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    assign wr_sel[i] = cfg_we && (cfg_idx == IDX_W'(i));
    icn_node #(.VEC_W(VEC_W)) u_node (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .req_set     (req_set[i]),
      .wr_en       (wr_sel[i]),
      .wr_vec      (cfg_vec),
      .grant_in    (grant[i]),
      .grant_out   (grant[i+1]),
      .claim       (claim[i]),
      .pend        (pend[i]),
      .vec_claimed (vec_flat[i*VEC_W +: VEC_W])
    );
  end

  icn_vec_out #(.NODES(NODES), .VEC_W(VEC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .claim     (claim),
    .vec_flat  (vec_flat),
    .vec_valid (vec_valid),
    .vec_data  (vec_data)
  );

  assign irq_out = |pend;
  assign ack_out = grant[NODES];

  assert_valid_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    vec_valid |-> $past(int_ack));

  assert_irq_rise_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq_out) |-> $past(|req_set));

  assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_out |-> (int_ack && !irq_out));
endmodule

// File: tb/irq_daisy_chain_tb.sv
`timescale 1ns/1ps
module irq_daisy_chain_tb;
  localparam int N  = 6;
  localparam int VW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_set;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [VW-1:0] cfg_vec;
  logic          int_ack;
  logic          irq_out, ack_out, vec_valid;
  logic [VW-1:0] vec_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [N-1:0]  mp;
  logic [VW-1:0] mv [N];
  logic          e_valid;
  logic [VW-1:0] e_data;

  always #2.5 clk = ~clk;

  irq_daisy_chain #(.NODES(N), .VEC_W(VW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .int_ack(int_ack),
    .irq_out(irq_out), .ack_out(ack_out), .vec_valid(vec_valid),
    .vec_data(vec_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int first_pend(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  // One cycle: drive inputs after a falling edge, check the pass-through,
  // advance the model, then check registered outputs at the next falling edge.
  task automatic step(input logic [N-1:0] rq, input logic we, input logic [IW-1:0] idx,
                      input logic [VW-1:0] vv, input logic ack);
    int w;
    req_set = rq; cfg_we = we; cfg_idx = idx; cfg_vec = vv; int_ack = ack;
    #1;
    chk("R6 ack_out", ack_out, ack && (mp == '0));
    w = ack ? first_pend(mp) : -1;
    e_valid = (w >= 0);
    e_data  = (w >= 0) ? mv[w] : '0;   // R9: word before any write this cycle
    if (w >= 0) mp[w] = 1'b0;          // R7
    mp = mp | rq;                      // R2
    if (we && idx < N) mv[idx] = vv;   // R8
    @(posedge clk);
    @(negedge clk);
    chk("R4 vec_valid", vec_valid, e_valid);
    chk(e_valid ? "R3 vec_data" : "R5 vec_data", vec_data, e_data);
    chk("R2 irq_out", irq_out, |mp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c));
    rst_n = 1'b0; req_set = '0; cfg_we = 0; cfg_idx = '0; cfg_vec = '0; int_ack = 0;
    mp = '0;
    for (int i = 0; i < N; i++) mv[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq_out", irq_out, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 vec_data", vec_data, 0);
    chk("R1 ack_out", ack_out, 0);
    // R1: words are zero; claim node 3 without loading it
    step(6'b001000, 0, 0, 0, 0);
    step(6'b000000, 0, 0, 0, 1);
    // R5/R6: acknowledge with nothing pending
    step(6'b000000, 0, 0, 0, 1);
    // R8: load all words, plus out-of-range writes that must change nothing
    for (int i = 0; i < N; i++) step('0, 1, IW'(i), VW'(8'h40 + i), 0);
    step('0, 1, 3'd6, 8'hEE, 0);
    step('0, 1, 3'd7, 8'hDD, 0);
    // R10: all pending, no ack for a while
    step('1, 0, 0, 0, 0);
    step('0, 0, 0, 0, 0);
    // R3/R7: drain in order
    for (int i = 0; i < N; i++) step('0, 0, 0, 0, 1);
    step('0, 0, 0, 0, 1);
    // R7: re-request the winner in the claiming cycle
    step(6'b000100, 0, 0, 0, 0);
    step(6'b000100, 0, 0, 0, 1);
    step('0, 0, 0, 0, 1);
    // R9: rewrite the winner during its claim
    step(6'b010000, 0, 0, 0, 0);
    step('0, 1, 3'd4, 8'hA5, 1);
    step(6'b010000, 0, 0, 0, 0);
    step('0, 0, 0, 0, 1);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r;
      r = '0;
      for (int i = 0; i < N; i++) r[i] = ($urandom % 8) == 0;
      step(r, ($urandom % 5) == 0, IW'($urandom % 8), VW'($urandom), ($urandom % 3) == 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule